// File: doc/BRIEF.md
# Pulse-Distance Key Code Transmitter

This block sends a key scan code and the state of a shift key to a receiver over one pulse line. All pulses have the same width. Each bit is carried by the time from one pulse to the next, measured in units of a prescaled tick, nominally about 1.024 ms: a 4 MHz base clock divided by 64 and then by 64 again.

A key event is presented as a level on `key_valid_i` together with `scan_code_i` and `shift_i`. When the transmitter is idle it captures these values and sends a double word. A single word is a start pulse followed by seven bit-carrying pulses. The double word is two such words separated by a fixed gap. For as long as the key stays pressed, the double word is sent again after a longer fixed gap. The receiver gates the line with its ready input, so a pulse reaches `pulse_o` only while `rdy_i` is high.

Top module: `pd_keytx`

## Requirements
- R1: All gaps are counted in `tick_i` pulses. A pulse is held internally from the tick edge that emits it until the next tick edge, so it is one tick interval wide.
- R2: A key is accepted on a clock edge where `busy_o` is low and `key_valid_i` is high. The start pulse of the first word is emitted at the first tick after acceptance.
- R3: The gap before each bit pulse encodes the bit. With `ONE_IS_SHORT`=1, a 1 uses `GAP_SHORT` (5) ticks and a 0 uses `GAP_LONG` (7) ticks. `ONE_IS_SHORT`=0 swaps the two meanings.
- R4: A word has 8 pulses: the start pulse, then the shift bit (`shift_i`, 1 = pressed), then `scan_code_i` bit 0 up to bit 5.
- R5: The start pulse of the second word follows the last pulse of the first word by `WORD_GAP` (14) ticks and carries the same word.
- R6: If `key_valid_i` is high when the last pulse of a double word is emitted, the next double word starts `REPEAT_GAP` (19) ticks later with the originally captured code. Otherwise transmission ends.
- R7: `pulse_o` is the internal pulse gated by `rdy_i`. While `rdy_i` is low, `pulse_o` stays low, and the timing of the transmission is unchanged.
- R8: While `busy_o` is high, changes on `scan_code_i`, `shift_i` and `key_valid_i` do not alter the word being sent. A short `key_valid_i` pulse during a word does not add a repeat.
- R9: `busy_o` rises on the clock edge that accepts a key. It falls on the tick edge that ends the final pulse.
- R10: After reset, `pulse_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock strobe per time unit |
| key_valid_i | input | 1 | Key pressed / code present |
| scan_code_i | input | CODE_W | Key scan code |
| shift_i | input | 1 | Shift key level |
| rdy_i | input | 1 | Receiver ready, gates the pulse line |
| pulse_o | output | 1 | Pulse line |
| busy_o | output | 1 | Transmission in progress |

## Verification
The bench uses the default gaps (5, 7, 14, 19 ticks), a 6-bit code and `ONE_IS_SHORT`=1. It strobes `tick_i` every third clock, so each gap appears as three times its tick count in clocks, and a width or alignment error of one clock shows up as an interval error. The seven-bit word makes all-zero, all-one and mixed codes cheap to send with both shift states. The small repeat gap lets a held key produce a second double word within a few hundred clocks.

// File: rtl/pd_keytx_pkg.sv
package pd_keytx_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tx_state_e;
endpackage

// File: rtl/pd_keytx_bit_gap.sv
module pd_keytx_bit_gap #(
  parameter int GAP_SHORT    = 5,
  parameter int GAP_LONG     = 7,
  parameter bit ONE_IS_SHORT = 1'b1,
  parameter int CNT_W        = 5
) (
  input  logic             bit_i,
  output logic [CNT_W-1:0] gap_o
);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(GAP_SHORT);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(GAP_LONG);

  if (ONE_IS_SHORT) begin : g_one_short
    assign gap_o = bit_i ? SHORT_V : LONG_V;
  end else begin : g_one_long
    assign gap_o = bit_i ? LONG_V : SHORT_V;
  end
endmodule

// File: rtl/pd_keytx_timer.sv
module pd_keytx_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/pd_keytx.sv
module pd_keytx
  import pd_keytx_pkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int GAP_SHORT    = 5,
  parameter int GAP_LONG     = 7,
  parameter int WORD_GAP     = 14,
  parameter int REPEAT_GAP   = 19,
  parameter bit ONE_IS_SHORT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              key_valid_i,
  input  logic [CODE_W-1:0] scan_code_i,
  input  logic              shift_i,
  input  logic              rdy_i,
  output logic              pulse_o,
  output logic              busy_o
);
  localparam int WORD_W  = CODE_W + 1;
  localparam int IDX_W   = $clog2(WORD_W + 1);
  localparam int EXT_W   = 2 ** IDX_W;
  localparam int MAX_GAP = (REPEAT_GAP > WORD_GAP) ? REPEAT_GAP : WORD_GAP;
  localparam int CNT_W   = $clog2(MAX_GAP + GAP_LONG + GAP_SHORT + 1);

  tx_state_e         state_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              second_q;
  logic              pulse_q;

  logic              fire;
  logic              accept;
  logic              last_pulse;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  bit_gap;
  logic [EXT_W-1:0]  word_ext;

  assign word_ext   = {{(EXT_W-WORD_W){1'b0}}, word_q};
  assign accept     = (state_q == ST_IDLE) && !pulse_q && key_valid_i;
  assign last_pulse = (idx_q == IDX_W'(WORD_W));

  pd_keytx_bit_gap #(
    .GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG),
    .ONE_IS_SHORT(ONE_IS_SHORT), .CNT_W(CNT_W)
  ) u_gap (
    .bit_i (word_ext[idx_q]),
    .gap_o (bit_gap)
  );

  pd_keytx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .fire_o     (fire)
  );

  // next gap chosen on the edge that emits a pulse
  always_comb begin
    load     = 1'b0;
    load_val = CNT_W'(1);
    if (accept) begin
      load = 1'b1;
    end else if (state_q == ST_RUN && fire) begin
      if (!last_pulse) begin
        load     = 1'b1;
        load_val = bit_gap;
      end else if (!second_q) begin
        load     = 1'b1;
        load_val = CNT_W'(WORD_GAP);
      end else if (key_valid_i) begin
        load     = 1'b1;
        load_val = CNT_W'(REPEAT_GAP);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      idx_q    <= '0;
      second_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (tick_i) pulse_q <= fire && (state_q == ST_RUN);
      if (accept) begin
        state_q  <= ST_RUN;
        word_q   <= {scan_code_i, shift_i};
        idx_q    <= '0;
        second_q <= 1'b0;
      end else if (state_q == ST_RUN && fire) begin
        if (!last_pulse) begin
          idx_q <= idx_q + IDX_W'(1);
        end else if (!second_q) begin
          idx_q    <= '0;
          second_q <= 1'b1;
        end else if (key_valid_i) begin
          idx_q    <= '0;
          second_q <= 1'b0;
        end else begin
          state_q <= ST_IDLE;
        end
      end
    end
  end

  assign pulse_o = pulse_q && rdy_i;
  assign busy_o  = (state_q == ST_RUN) || pulse_q;
endmodule

// File: rtl/pd_keytx_chk.sv
module pd_keytx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic key_valid_i,
  input logic rdy_i,
  input logic pulse_o,
  input logic busy_o
);
  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && key_valid_i |=> busy_o);

  // R1
  pulse_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) && $past(rdy_i) |-> $past(tick_i));

  // R1
  pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) && $past(rdy_i) && rdy_i |-> pulse_o == $past(pulse_o));

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tick_i));

  // R7
  rdy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);
endmodule

bind pd_keytx pd_keytx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .key_valid_i (key_valid_i),
  .rdy_i       (rdy_i),
  .pulse_o     (pulse_o),
  .busy_o      (busy_o)
);

// File: tb/pd_keytx_tb_top.sv
module pd_keytx_tb_top;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 3;
  localparam int SHORT_G  = 5;
  localparam int LONG_G   = 7;
  localparam int WGAP     = 14;
  localparam int RGAP     = 19;
  // {hold, shift, code[5:0]}
  localparam logic [7:0] VEC [5] = '{8'h2A, 8'h55, 8'h00, 8'h7F, 8'h89};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       key_valid_i = 1'b0;
  logic [5:0] scan_code_i = '0;
  logic       shift_i = 1'b0;
  logic       rdy_i = 1'b1;
  logic       pulse_o, busy_o;

  int total = 0, fails = 0;
  int cyc = 0, npulse = 0, busy_fall = -1;
  int ts [64];
  logic prev_p = 1'b0, prev_b = 1'b0;
  int div = 0;

  always #(CLK_P/2) clk = ~clk;

  pd_keytx #(.CODE_W(6), .GAP_SHORT(SHORT_G), .GAP_LONG(LONG_G),
             .WORD_GAP(WGAP), .REPEAT_GAP(RGAP), .ONE_IS_SHORT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .key_valid_i(key_valid_i),
    .scan_code_i(scan_code_i), .shift_i(shift_i), .rdy_i(rdy_i),
    .pulse_o(pulse_o), .busy_o(busy_o));

  always @(posedge clk) begin
    div    <= (div == TICK_DIV-1) ? 0 : div + 1;
    tick_i <= (div == TICK_DIV-1);
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pulse_o && !prev_p) begin
      if (npulse < 64) ts[npulse] = cyc;
      npulse = npulse + 1;
    end
    if (prev_b && !busy_o) busy_fall = cyc;
    prev_p = pulse_o;
    prev_b = busy_o;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bgap(input logic b);
    return b ? SHORT_G : LONG_G;
  endfunction

  // expected interval k for word w (7 bits, bit0 = shift)
  function automatic int exp_gap(input logic [6:0] w, input int k);
    int j;
    j = (k >= 16) ? k - 16 : k;
    if (k == 15) return RGAP;
    if (j < 7)  return bgap(w[j]);
    if (j == 7) return WGAP;
    return bgap(w[j-8]);
  endfunction

  task automatic send(input logic [5:0] code, input logic sh, input logic hold,
                      input bit check_busy);
    npulse = 0; busy_fall = -1;
    @(posedge clk); #1;
    key_valid_i = 1'b1; scan_code_i = code; shift_i = sh;
    @(posedge clk); #1;
    if (check_busy) check("R9 busy rise", int'(busy_o), 1);
    if (!hold) key_valid_i = 1'b0;
    else begin
      while (npulse < 17) @(negedge clk);
      #1 key_valid_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  task automatic check_word(input string req, input logic [6:0] w, input int n);
    int bad = -1;
    check({req, " pulse count"}, npulse, n);
    for (int k = 0; k < n-1 && k < npulse-1; k++)
      if (bad < 0 && (ts[k+1]-ts[k]) != exp_gap(w, k)*TICK_DIV) bad = k;
    if (bad >= 0) check({req, " interval"}, ts[bad+1]-ts[bad], exp_gap(w, bad)*TICK_DIV);
    else check({req, " intervals"}, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total-fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check("R10 pulse reset", int'(pulse_o), 0);
    check("R10 busy reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R4 R5 R6 R9 table
    for (int v = 0; v < 5; v++) begin
      logic [7:0] e;
      int n;
      e = VEC[v];
      n = e[7] ? 32 : 16;
      send(e[5:0], e[6], e[7], 1'b1);
      check_word(e[7] ? "R6 held" : "R3 R4 R5 word", {e[5:0], e[6]}, n);
      check("R9 busy fall", busy_fall, ts[(npulse > 0 && npulse <= 64) ? npulse-1 : 0] + TICK_DIV);
    end

    // R2 start pulse at first tick after accept: interval bounded by one tick
    begin
      int acc;
      npulse = 0;
      @(posedge clk); #1;
      key_valid_i = 1'b1; scan_code_i = 6'h01; shift_i = 1'b0;
      acc = cyc;
      @(posedge clk); #1 key_valid_i = 1'b0;
      while (busy_o) @(negedge clk);
      repeat (10) @(negedge clk);
      total++;
      if (ts[0] - acc < 1 || ts[0] - acc > TICK_DIV + 1) begin
        fails++;
        $display("FAIL R2 start delay actual=%0d expected<=%0d", ts[0]-acc, TICK_DIV+1);
      end
    end

    // R7 ready low: no pulses, busy still completes
    rdy_i = 1'b0;
    send(6'h2D, 1'b1, 1'b0, 1'b0);
    check("R7 gated pulses", npulse, 0);
    check("R7 busy done", int'(busy_o), 0);
    rdy_i = 1'b1;

    // R8 inputs while busy ignored
    npulse = 0;
    @(posedge clk); #1;
    key_valid_i = 1'b1; scan_code_i = 6'h0C; shift_i = 1'b1;
    @(posedge clk); #1 key_valid_i = 1'b0;
    while (npulse < 3) @(negedge clk);
    #1 key_valid_i = 1'b1; scan_code_i = 6'h33; shift_i = 1'b0;
    repeat (5) @(posedge clk);
    #1 key_valid_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (60) @(negedge clk);
    check_word("R8 ignored", {6'h0C, 1'b1}, 16);

    $display("%0d/%0d checks passed", total-fails, total);
    $finish;
  end
endmodule